// File: doc/BRIEF.md
# ALU Flag and Interrupt-Gate Unit

This block is the arithmetic corner of a small 8-bit processor core. It combines four pieces:

- a combinational datapath that adds, subtracts, masks and shifts one-bit;
- a condition code byte that records the result flags;
- an interrupt acceptance gate driven by control fields held in that same byte;
- a generator for the 16-bit address of a general-purpose register.

Instruction decode sits outside the block. It presents an operation code and two operands, pulses `op_en` to commit the flags, and may also rewrite the whole condition byte through a software write port.

The condition byte uses this bit layout:

| Bit | Field |
|-----|-------|
| 7 | H, half-carry |
| 6 | IE, interrupt enable |
| 5:4 | IL, current level |
| 3 | N |
| 2 | Z |
| 1 | V |
| 0 | C |

Interrupt levels are numbered so that a smaller value is more urgent. The gate accepts a pending request only if interrupts are enabled and the request level is strictly more urgent than IL. Level 3 is therefore never accepted, and setting IL to 0 blocks every request.

Top module: `alu_ccr_unit`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, AND=4, OR=5, SHL=6, SHR=7. ADD and ADDC give a+b(+C); SUB and SUBC give a-b(-C). C takes the carry out of bit 7 or the borrow into bit 7.
- R2: For the four arithmetic codes, H is set on a carry from bit 3 into bit 4 (addition) or a borrow from bit 4 into bit 3 (subtraction), and cleared otherwise.
- R3: For the four arithmetic codes, V is set on two's-complement overflow and cleared otherwise.
- R4: For every code, N takes result bit 7 and Z is set exactly when the 8-bit result is zero.
- R5: AND and OR produce the bitwise result. They leave H, V and C unchanged.
- R6: SHL gives {a[6:0],0} with C=a[7]. SHR gives {0,a[7:1]} with C=a[0]. Both leave H and V unchanged and ignore operand b.
- R7: After reset the condition byte reads 0x30 (IE=0, IL=3, flags 0). The layout is H=7, IE=6, IL=5:4, N=3, Z=2, V=1, C=0. A software write loads the whole byte.
- R8: When an operation and a software write fall in the same cycle, each flag the operation updates takes the operation's value. Every other bit takes the written value.
- R9: `irq_ack` is 1 exactly when `irq_req`=1, IE=1 and `irq_lvl` < IL. It is combinational from the current byte.
- R10: `gpr_addr` = {6'b0, 2'b01, bank_ptr[4:0], opc_sel[2:0]}.
- R11: With neither `op_en` nor `ccr_wr_en` asserted, the condition byte holds its value whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Commit flags of the current operation |
| op | input | 3 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| ccr_wr_en | input | 1 | Software write of the condition byte |
| ccr_wdata | input | 8 | Software write data |
| ccr_q | output | 8 | Current condition byte |
| irq_req | input | 1 | Interrupt request pending |
| irq_lvl | input | 2 | Level of the pending request |
| irq_ack | output | 1 | Request accepted |
| bank_ptr | input | 5 | Register-bank pointer |
| opc_sel | input | 3 | Low opcode bits selecting a register |
| gpr_addr | output | 16 | General-purpose register address |

## Verification
An operation committing flags and a software write of the condition byte can land on the same clock edge, and the merge rule for that case is the main hazard. The operand sweep raises the write on roughly one vector in seven, with scrambled write data and whatever operation is current. Every arithmetic, logic and shift code is therefore exercised against a simultaneous write. After each edge the whole byte is compared with a model that takes the operation-touched flags from the operation and all other bits from the write data.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_SHL  = 3'd6,
    OP_SHR  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic             h;
    logic             ie;
    logic [LVL_W-1:0] il;
    logic             n;
    logic             z;
    logic             v;
    logic             c;
  } ccr_t;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flag_set_t;

  localparam ccr_t CCR_RST = ccr_t'(8'h30);
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import ccr_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output flag_set_t       flg,
  output flag_set_t       upd
);
  localparam int HB = DW / 2;

  logic [DW:0] wide;
  logic [HB:0] half;
  logic        cy;

  always_comb begin
    res  = '0;
    flg  = '0;
    upd  = '0;
    wide = '0;
    half = '0;
    cy   = (op == OP_ADDC || op == OP_SUBC) ? cin : 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        wide  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cy};
        half  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cy};
        res   = wide[DW-1:0];
        flg.c = wide[DW];
        flg.h = half[HB];
        flg.v = (a[DW-1] == b[DW-1]) && (wide[DW-1] != a[DW-1]);
        upd   = '1;
      end
      OP_SUB, OP_SUBC: begin
        wide  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cy};
        half  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cy};
        res   = wide[DW-1:0];
        flg.c = wide[DW];
        flg.h = half[HB];
        flg.v = (a[DW-1] != b[DW-1]) && (wide[DW-1] != a[DW-1]);
        upd   = '1;
      end
      OP_AND: begin
        res   = a & b;
        upd.n = 1'b1;
        upd.z = 1'b1;
      end
      OP_OR: begin
        res   = a | b;
        upd.n = 1'b1;
        upd.z = 1'b1;
      end
      OP_SHL: begin
        res   = {a[DW-2:0], 1'b0};
        flg.c = a[DW-1];
        upd.n = 1'b1;
        upd.z = 1'b1;
        upd.c = 1'b1;
      end
      OP_SHR: begin
        res   = {1'b0, a[DW-1:1]};
        flg.c = a[0];
        upd.n = 1'b1;
        upd.z = 1'b1;
        upd.c = 1'b1;
      end
      default: res = '0;
    endcase
    flg.n = res[DW-1];
    flg.z = (res == '0);
  end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import ccr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      op_en,
  input  flag_set_t flg,
  input  flag_set_t upd,
  input  logic      wr_en,
  input  ccr_t      wdata,
  output ccr_t      ccr_q
);
  ccr_t ccr_d;
  logic ld;

  assign ld = op_en | wr_en;

  always_comb begin
    ccr_d = ccr_q;
    if (wr_en) ccr_d = wdata;
    if (op_en) begin
      if (upd.h) ccr_d.h = flg.h;
      if (upd.n) ccr_d.n = flg.n;
      if (upd.z) ccr_d.z = flg.z;
      if (upd.v) ccr_d.v = flg.v;
      if (upd.c) ccr_d.c = flg.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ccr_q <= CCR_RST;
    else if (ld) ccr_q <= ccr_d;
  end

  // R11
  ccr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en && !wr_en) |=> $stable(ccr_q));

  // R8
  ccr_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && wr_en && upd.c) |=> (ccr_q.c == $past(flg.c)));

  // R5
  ccr_ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !wr_en) |=> (ccr_q.ie == $past(ccr_q.ie) && ccr_q.il == $past(ccr_q.il)));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LW = 2
) (
  input  logic          ie,
  input  logic [LW-1:0] cur_lvl,
  input  logic          req,
  input  logic [LW-1:0] req_lvl,
  output logic          ack
);
  localparam logic [LW-1:0] LVL_MIN = '1;

  assign ack = req & ie & (req_lvl < cur_lvl);

  always_comb begin
    // R9
    if (ack) irq_gate_lvl_chk: assert (ie && req_lvl != LVL_MIN);
  end
endmodule

// File: rtl/gpr_addr_gen.sv
module gpr_addr_gen #(
  parameter int                BANK_W = 5,
  parameter int                SEL_W  = 3,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0100
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] addr
);
  localparam int LOW_W = BANK_W + SEL_W;

  assign addr = {BASE[ADDR_W-1:LOW_W], bank, sel};
endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
  import ccr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 5,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [2:0]        op,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  output logic [DW-1:0]     result,
  input  logic              ccr_wr_en,
  input  logic [7:0]        ccr_wdata,
  output logic [7:0]        ccr_q,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_lvl,
  output logic              irq_ack,
  input  logic [BANK_W-1:0] bank_ptr,
  input  logic [SEL_W-1:0]  opc_sel,
  output logic [ADDR_W-1:0] gpr_addr
);
  logic      srst_n;
  flag_set_t flg;
  flag_set_t upd;
  ccr_t      ccr;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  alu_core #(.DW(DW)) u_alu (
    .op  (alu_op_e'(op)),
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (ccr.c),
    .res (result),
    .flg (flg),
    .upd (upd)
  );

  ccr_reg u_ccr (
    .clk   (clk),
    .rst_n (srst_n),
    .op_en (op_en),
    .flg   (flg),
    .upd   (upd),
    .wr_en (ccr_wr_en),
    .wdata (ccr_t'(ccr_wdata)),
    .ccr_q (ccr)
  );

  irq_gate #(.LW(LVL_W)) u_irq (
    .ie      (ccr.ie),
    .cur_lvl (ccr.il),
    .req     (irq_req),
    .req_lvl (irq_lvl),
    .ack     (irq_ack)
  );

  gpr_addr_gen #(
    .BANK_W (BANK_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_gpr (
    .bank (bank_ptr),
    .sel  (opc_sel),
    .addr (gpr_addr)
  );

  assign ccr_q = ccr;

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    op_en |=> (ccr.z == ($past(result) == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    op_en |=> (ccr.n == $past(result[DW-1])));
endmodule

// File: tb/sim_alu_ccr_unit.sv
module sim_alu_ccr_unit;
  logic        clk;
  logic        rst_n;
  logic        op_en;
  logic [2:0]  op;
  logic [7:0]  opnd_a;
  logic [7:0]  opnd_b;
  logic [7:0]  result;
  logic        ccr_wr_en;
  logic [7:0]  ccr_wdata;
  logic [7:0]  ccr_q;
  logic        irq_req;
  logic [1:0]  irq_lvl;
  logic        irq_ack;
  logic [4:0]  bank_ptr;
  logic [2:0]  opc_sel;
  logic [15:0] gpr_addr;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  alu_ccr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .ccr_wr_en(ccr_wr_en), .ccr_wdata(ccr_wdata), .ccr_q(ccr_q),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_ack(irq_ack),
    .bank_ptr(bank_ptr), .opc_sel(opc_sel), .gpr_addr(gpr_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Returns {result, next condition byte}; layout H7 IE6 IL5:4 N3 Z2 V1 C0
  function automatic logic [15:0] mdl(input int opc, input int a, input int b,
                                       input logic [7:0] cc, input logic wr,
                                       input logic [7:0] wd);
    logic [7:0] nx;
    int r, cin, s, sa, sb;
    bit h, v, c, th, tv, tc;
    nx = wr ? wd : cc;
    cin = (opc == 1 || opc == 3) ? int'(cc[0]) : 0;
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    th = 0; tv = 0; tc = 0; h = 0; v = 0; c = 0; r = 0;
    if (opc <= 1) begin
      s = a + b + cin; r = s % 256; c = (s > 255);
      h = ((a % 16) + (b % 16) + cin) > 15;
      s = sa + sb + cin; v = (s > 127) || (s < -128);
      th = 1; tv = 1; tc = 1;
    end else if (opc <= 3) begin
      s = a - b - cin; r = (s + 256) % 256; c = (s < 0);
      h = ((a % 16) - (b % 16) - cin) < 0;
      s = sa - sb - cin; v = (s > 127) || (s < -128);
      th = 1; tv = 1; tc = 1;
    end else if (opc == 4) r = a & b;
    else if (opc == 5) r = a | b;
    else if (opc == 6) begin r = (a * 2) % 256; c = (a >= 128); tc = 1; end
    else begin r = a / 2; c = (a % 2) == 1; tc = 1; end
    if (th) nx[7] = h;
    if (tv) nx[1] = v;
    if (tc) nx[0] = c;
    nx[3] = (r >= 128);
    nx[2] = (r == 0);
    return {r[7:0], nx};
  endfunction

  initial begin
    logic [7:0]  mcc;
    logic [15:0] m;
    string tg;
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; op_en = 0; op = 0; opnd_a = 0; opnd_b = 0;
    ccr_wr_en = 0; ccr_wdata = 0; irq_req = 0; irq_lvl = 0;
    bank_ptr = 0; opc_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state
    chk("R7 reset byte", {8'h0, ccr_q}, 16'h0030);
    irq_req = 1; irq_lvl = 0;
    #1 chk("R9 no ack after reset", {15'h0, irq_ack}, 16'h0);
    irq_req = 0;

    // Operand sweep over all codes; simultaneous writes exercise R8
    mcc = 8'h30;
    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 32; j++) begin
          @(negedge clk);
          op = 3'(o); opnd_a = 8'(a); opnd_b = 8'(j * 8 + j % 8);
          op_en = 1'b1;
          ccr_wr_en = ((a + j) % 7 == 0);
          ccr_wdata = 8'((a * 37 + j * 11 + o * 5) % 256);
          m = mdl(o, a, j * 8 + j % 8, mcc, ccr_wr_en, ccr_wdata);
          tg = (o < 4) ? "R1 result" : (o < 6) ? "R5 result" : "R6 result";
          #2 chk(tg, {8'h0, result}, {8'h0, m[15:8]});
          @(posedge clk);
          #1;
          if (ccr_wr_en) tg = "R8 merged byte";
          else if (o < 4) tg = "R1 R2 R3 R4 flags";
          else if (o < 6) tg = "R5 R4 flags";
          else tg = "R6 R4 flags";
          chk(tg, {8'h0, ccr_q}, {8'h0, m[7:0]});
          mcc = m[7:0];
        end
      end
    end

    // R11 hold with no enable
    @(negedge clk);
    op_en = 0; ccr_wr_en = 1; ccr_wdata = 8'hA5;
    @(negedge clk);
    ccr_wr_en = 0;
    for (int k = 0; k < 4; k++) begin
      op = 3'(k); opnd_a = 8'(k * 61); opnd_b = 8'(255 - k);
      @(negedge clk);
      chk("R11 hold", {8'h0, ccr_q}, 16'h00A5);
    end

    // R9 acceptance sweep
    for (int ie = 0; ie < 2; ie++) begin
      for (int il = 0; il < 4; il++) begin
        @(negedge clk);
        ccr_wr_en = 1; ccr_wdata = 8'((ie << 6) | (il << 4) | 5);
        @(negedge clk);
        ccr_wr_en = 0;
        for (int rq = 0; rq < 2; rq++) begin
          for (int lv = 0; lv < 4; lv++) begin
            irq_req = rq[0]; irq_lvl = 2'(lv);
            #1 chk("R9 accept", {15'h0, irq_ack},
                   {15'h0, (rq == 1 && ie == 1 && lv < il) ? 1'b1 : 1'b0});
          end
        end
      end
    end
    irq_req = 0;

    // R10 address formation sweep
    for (int bk = 0; bk < 32; bk++) begin
      for (int sl = 0; sl < 8; sl++) begin
        bank_ptr = 5'(bk); opc_sel = 3'(sl);
        #1 chk("R10 address", gpr_addr, 16'(256 + bk * 8 + sl));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule